// File: doc/BRIEF.md
# Dual-Bank GPIO Expander Core with Interrupt-on-Change

This core provides sixteen general-purpose pins, arranged as two banks of eight (A and B), behind a simple synchronous register bus. Each pin can be an input or an output, can have its read polarity inverted, and can have a pull-up request exported to the pad ring. A host programs the core with single-cycle writes. It reads back one register per read strobe, and the data appears on the cycle after the strobe.

Each bank has its own interrupt engine, built as a two-state machine. In state `ST_IDLE` the bank watches its enabled pins. Transition `ARM` moves it to `ST_HELD` when any enabled pin fires. On `ARM` the bank records the lowest-numbered firing pin in its flag register and freezes a polarity-adjusted snapshot of the bank in its capture register. In `ST_HELD` further pin activity is ignored. Transition `CLEAR` returns the bank to `ST_IDLE` on a clearing read. The configuration register selects which read clears: the port read or the capture read. A pin fires in one of two ways, chosen per pin. In change mode it fires when its sample differs from the previous sample. In level mode it fires while it differs from a default-compare bit.

Two interrupt outputs, one per bank, each come with an output enable. They can be active low, active high or open drain, and they can be mirrored so that either bank drives both outputs.

Top module: `pinx_core`

## Requirements
- R1: After reset, both direction registers read 0xFF, every other register reads 0x00, `pin_oe` is all zero, and both interrupt outputs are inactive (`irq_*_out`=1, `irq_*_oe`=1).
- R2: The bus address is register index×2 + bank, with bank A at even addresses. The register indices are: direction 0, polarity 1, interrupt enable 2, default compare 3, interrupt control 4, configuration 5, pull-up 6, flag 7, capture 8, port 9, output latch 10. A write to one bank does not alter the other bank.
- R3: `pin_out` follows the output latch. A pin's `pin_oe` bit is 1 exactly when its direction bit is 0. Reading the output latch returns the latch, not the pin level.
- R4: A port read returns each pin's sampled level XOR its polarity bit.
- R5: With interrupt-control bit 0 (change mode), a change on an enabled pin makes its bank pending.
- R6: With interrupt-control bit 1 (level mode), a pin fires while its raw sampled level differs from its default-compare bit. If the condition still holds, the bank becomes pending again on the cycle after a clear.
- R7: The flag register holds only the lowest-numbered firing enabled pin. The two banks flag independently. Pins with interrupt enable 0 never flag.
- R8: On becoming pending, the capture register stores the polarity-adjusted bank state and holds it while pins keep changing.
- R9: Configuration bit 0 selects how a pending bank clears. When it is 0, a port read of that bank clears the pending state. When it is 1, only a capture read clears it.
- R10: Writes to the flag, capture and port registers have no effect.
- R11: The configuration register is a single register that is reachable at both bank addresses.
- R12: Configuration bit 1 makes the interrupt outputs active high, and active low when it is 0. Bit 2 selects open drain: the output is 0 and its enable is asserted only while the interrupt is active. Bit 6 ORs both banks' pending states onto both outputs.
- R13: The pull-up registers are exported unchanged on `pullup_en`, with bank A in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (5) | Register address (index×2 + bank) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W (8) | Write data |
| rd_en | input | 1 | Read strobe; may clear a pending bank |
| rd_data | output | W (8) | Read data, valid the cycle after `rd_en` |
| pin_in | input | 2W (16) | Pin levels, bank A low byte |
| pin_out | output | 2W (16) | Output levels from the latches |
| pin_oe | output | 2W (16) | Per-pin drive enable |
| pullup_en | output | 2W (16) | Pull-up requests |
| irq_a_out | output | 1 | Bank A interrupt level |
| irq_a_oe | output | 1 | Bank A interrupt drive enable |
| irq_b_out | output | 1 | Bank B interrupt level |
| irq_b_oe | output | 1 | Bank B interrupt drive enable |

## Verification
The interrupt engine is driven with four patterns. A simultaneous multi-pin toggle in one bank that includes a disabled pin separates lowest-pin selection from enable masking. A toggle of a disabled pin alone shows that masked pins never flag. Coincident toggles in both banks show that the banks flag independently and do not overwrite each other. A held level condition tells a true clear from a clear that re-arms on the next cycle. While a bank is pending, pins keep changing and both clearing reads are tried under each setting of the clear-select bit, which shows whether the snapshot is frozen and which read ends the pending state. The output stage is then swept through its polarity, mirroring and open-drain settings while only bank B is pending.

// File: rtl/pinx_pkg.sv
package pinx_pkg;
    // register indices (address = index*2 + bank)
    localparam logic [3:0] IX_DIR   = 4'd0;
    localparam logic [3:0] IX_IPOL  = 4'd1;
    localparam logic [3:0] IX_INTEN = 4'd2;
    localparam logic [3:0] IX_DEFV  = 4'd3;
    localparam logic [3:0] IX_ICTL  = 4'd4;
    localparam logic [3:0] IX_CFG   = 4'd5;
    localparam logic [3:0] IX_PULL  = 4'd6;
    localparam logic [3:0] IX_FLAG  = 4'd7;
    localparam logic [3:0] IX_CAP   = 4'd8;
    localparam logic [3:0] IX_PORT  = 4'd9;
    localparam logic [3:0] IX_OLAT  = 4'd10;

    // configuration bit positions
    localparam int CB_CLRSEL = 0;
    localparam int CB_HIACT  = 1;
    localparam int CB_OPEND  = 2;
    localparam int CB_MIRROR = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } irq_st_e;
endpackage

// File: rtl/pinx_bank.sv
module pinx_bank
    import pinx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         wr_en,
    input  logic [3:0]   wr_idx,
    input  logic [W-1:0] wr_data,
    input  logic         clr,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] ipol_q,
    output logic [W-1:0] inten_q,
    output logic [W-1:0] defv_q,
    output logic [W-1:0] ictl_q,
    output logic [W-1:0] pull_q,
    output logic [W-1:0] olat_q,
    output logic [W-1:0] flag_q,
    output logic [W-1:0] cap_q,
    output logic [W-1:0] port_v,
    output logic         pend
);
    logic [W-1:0] samp_q, prev_q, trig, pick;
    irq_st_e      st_q, st_d;
    logic         arm;

    // host-writable registers; flag, capture and port indices fall to default
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '1;
            ipol_q  <= '0;
            inten_q <= '0;
            defv_q  <= '0;
            ictl_q  <= '0;
            pull_q  <= '0;
            olat_q  <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IX_DIR:   dir_q   <= wr_data;
                IX_IPOL:  ipol_q  <= wr_data;
                IX_INTEN: inten_q <= wr_data;
                IX_DEFV:  defv_q  <= wr_data;
                IX_ICTL:  ictl_q  <= wr_data;
                IX_PULL:  pull_q  <= wr_data;
                IX_OLAT:  olat_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    // pin sampling: current and previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            prev_q <= '0;
        end else begin
            samp_q <= pin_in;
            prev_q <= samp_q;
        end
    end

    assign trig = inten_q & ((ictl_q & (samp_q ^ defv_q)) | (~ictl_q & (samp_q ^ prev_q)));
    assign pick = trig & (~trig + W'(1));   // isolate lowest set bit

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state: ARM (idle->held), CLEAR (held->idle)
    always_comb begin
        st_d = st_q;
        arm  = 1'b0;
        unique case (st_q)
            ST_IDLE: if (|trig) begin
                st_d = ST_HELD;
                arm  = 1'b1;
            end
            ST_HELD: if (clr) st_d = ST_IDLE;
        endcase
    end

    // outputs: flag and frozen snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            cap_q  <= '0;
        end else if (arm) begin
            flag_q <= pick;
            cap_q  <= samp_q ^ ipol_q;
        end else if (st_q == ST_HELD && clr) begin
            flag_q <= '0;
        end
    end

    assign port_v = samp_q ^ ipol_q;
    assign pend   = (st_q == ST_HELD);
endmodule

// File: rtl/pinx_irq_drv.sv
module pinx_irq_drv (
    input  logic act,
    input  logic hi_act,
    input  logic opend,
    output logic out,
    output logic oe
);
    assign oe  = opend ? act  : 1'b1;
    assign out = opend ? 1'b0 : (hi_act ? act : ~act);
endmodule

// File: rtl/pinx_core.sv
module pinx_core
    import pinx_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    input  logic [2*W-1:0] pin_in,
    output logic [2*W-1:0] pin_out,
    output logic [2*W-1:0] pin_oe,
    output logic [2*W-1:0] pullup_en,
    output logic          irq_a_out,
    output logic          irq_a_oe,
    output logic          irq_b_out,
    output logic          irq_b_oe
);
    localparam int NB = 2;

    logic [AW-2:0] idx;
    logic          bsel;
    logic [W-1:0]  cfg_q;
    logic [W-1:0]  dir_v [NB], ipol_v [NB], inten_v [NB], defv_v [NB], ictl_v [NB];
    logic [W-1:0]  pull_v [NB], olat_v [NB], flag_v [NB], cap_v [NB], port_v [NB];
    logic [NB-1:0] pend, clr, act, irq_o, irq_e;

    assign idx  = addr[AW-1:1];
    assign bsel = addr[0];

    always_ff @(posedge clk) begin
        if (!rst_n)                         cfg_q <= '0;
        else if (wr_en && idx == IX_CFG)    cfg_q <= wr_data;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign clr[b] = rd_en && (bsel == 1'(b)) &&
                        (idx == (cfg_q[CB_CLRSEL] ? IX_CAP : IX_PORT));

        pinx_bank #(.W(W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .pin_in(pin_in[b*W +: W]),
            .wr_en(wr_en && (bsel == 1'(b))),
            .wr_idx(idx), .wr_data(wr_data), .clr(clr[b]),
            .dir_q(dir_v[b]), .ipol_q(ipol_v[b]), .inten_q(inten_v[b]),
            .defv_q(defv_v[b]), .ictl_q(ictl_v[b]), .pull_q(pull_v[b]),
            .olat_q(olat_v[b]), .flag_q(flag_v[b]), .cap_q(cap_v[b]),
            .port_v(port_v[b]), .pend(pend[b])
        );

        assign pin_out[b*W +: W]   = olat_v[b];
        assign pin_oe[b*W +: W]    = ~dir_v[b];
        assign pullup_en[b*W +: W] = pull_v[b];

        assign act[b] = pend[b] | (cfg_q[CB_MIRROR] & pend[NB-1-b]);

        pinx_irq_drv u_drv (
            .act(act[b]), .hi_act(cfg_q[CB_HIACT]), .opend(cfg_q[CB_OPEND]),
            .out(irq_o[b]), .oe(irq_e[b])
        );
    end

    assign irq_a_out = irq_o[0];
    assign irq_a_oe  = irq_e[0];
    assign irq_b_out = irq_o[1];
    assign irq_b_oe  = irq_e[1];

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            case (idx)
                IX_DIR:   rd_data <= dir_v[bsel];
                IX_IPOL:  rd_data <= ipol_v[bsel];
                IX_INTEN: rd_data <= inten_v[bsel];
                IX_DEFV:  rd_data <= defv_v[bsel];
                IX_ICTL:  rd_data <= ictl_v[bsel];
                IX_CFG:   rd_data <= cfg_q;
                IX_PULL:  rd_data <= pull_v[bsel];
                IX_FLAG:  rd_data <= flag_v[bsel];
                IX_CAP:   rd_data <= cap_v[bsel];
                IX_PORT:  rd_data <= port_v[bsel];
                IX_OLAT:  rd_data <= olat_v[bsel];
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/pinx_chk.sv
module pinx_chk #(
    parameter int W  = 8,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  cfg,
    input logic [1:0]    pend,
    input logic [W-1:0]  flag_a,
    input logic [W-1:0]  cap_a,
    input logic          irq_a_out,
    input logic          irq_a_oe
);
    logic clr_a;
    assign clr_a = rd_en && !addr[0] && (addr[AW-1:1] == (cfg[0] ? 4'd8 : 4'd9));

    // R7
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_a));

    // R7
    pend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> (flag_a != '0));

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !clr_a) |=> (pend[0] && $stable(cap_a)));

    // R9
    port_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && rd_en && addr == 5'd18 && !cfg[0]) |=> !pend[0]);

    // R12
    opend_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[2] |-> !irq_a_out);

    // R12
    push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[2] |-> irq_a_oe);
endmodule

bind pinx_core pinx_chk #(.W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cfg(cfg_q),
    .pend(pend), .flag_a(flag_v[0]), .cap_a(cap_v[0]),
    .irq_a_out(irq_a_out), .irq_a_oe(irq_a_oe)
);

// File: tb/pinx_core_bench.sv
`timescale 1ns/1ps
module pinx_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pullup_en;
    logic        irq_a_out, irq_a_oe, irq_b_out, irq_b_oe;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    pinx_core u_pinx_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pullup_en(pullup_en), .irq_a_out(irq_a_out),
        .irq_a_oe(irq_a_oe), .irq_b_out(irq_b_out), .irq_b_oe(irq_b_oe)
    );

    // addresses: index*2 + bank
    function automatic logic [4:0] ra(input int ix); return 5'(ix*2);   endfunction
    function automatic logic [4:0] rb(input int ix); return 5'(ix*2+1); endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // driver: issue a read and push the expected value to the scoreboard
    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pop and compare the cycle after each read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && rst_n) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL scoreboard: got %h expected nothing", rd_data);
                end else begin
                    chk(tag_q.pop_front(), 16'(rd_data), 16'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(ra(0), 8'hFF, "R1 dir A");
        rd(rb(0), 8'hFF, "R1 dir B");
        rd(ra(10), 8'h00, "R1 latch A");
        rd(rb(5), 8'h00, "R1 cfg");
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 irq a", {15'd0, irq_a_out & irq_a_oe}, 16'd1);
        chk("R1 irq b", {15'd0, irq_b_out & irq_b_oe}, 16'd1);

        // R3 latch and drive; R2 bank separation
        wr(ra(10), 8'h5A);
        wr(ra(0), 8'hF0);
        chk("R3 pin_out", pin_out, 16'h005A);
        chk("R3 pin_oe", pin_oe, 16'h000F);
        rd(ra(10), 8'h5A, "R3 latch readback");
        rd(rb(0), 8'hFF, "R2 dir B untouched");

        // R13 pull-ups
        wr(rb(6), 8'h81);
        chk("R13 pullup_en", pullup_en, 16'h8100);

        // R4 polarity
        pin_in = 16'h3CA5;
        wr(ra(1), 8'hFF);
        idle(2);
        rd(ra(9), 8'h5A, "R4 port A inverted");
        rd(rb(9), 8'h3C, "R4 port B");
        wr(ra(1), 8'h00);

        // R11 shared configuration
        wr(ra(5), 8'h22);
        rd(rb(5), 8'h22, "R11 cfg via B");
        wr(rb(5), 8'h00);
        rd(ra(5), 8'h00, "R11 cfg via A");

        // R5 change mode, R7 lowest pin, R8 snapshot, R9 clear
        wr(ra(2), 8'h0C);
        pin_in[7:0] = 8'hA8;          // toggles pins 0,2,3
        idle(3);
        chk("R5 irq a asserted", {15'd0, irq_a_out}, 16'd0);
        chk("R7 irq b quiet", {15'd0, irq_b_out}, 16'd1);
        rd(ra(7), 8'h04, "R7 lowest enabled pin");
        rd(ra(8), 8'hA8, "R8 capture");
        pin_in[7:0] = 8'h00;
        idle(3);
        rd(ra(8), 8'hA8, "R8 capture frozen");
        chk("R9 capture read no clear", {15'd0, irq_a_out}, 16'd0);
        rd(ra(9), 8'h00, "R9 port read");
        chk("R9 port read clears", {15'd0, irq_a_out}, 16'd1);
        rd(ra(7), 8'h00, "R9 flag cleared");
        pin_in[7:0] = 8'h01;          // disabled pin only
        idle(3);
        chk("R7 disabled pin", {15'd0, irq_a_out}, 16'd1);
        rd(ra(7), 8'h00, "R7 disabled no flag");

        // R7 banks independent
        wr(rb(2), 8'hFF);
        pin_in = 16'h7E09;            // B toggles 1,6; A toggles 3
        idle(3);
        rd(ra(7), 8'h08, "R7 flag A");
        rd(rb(7), 8'h02, "R7 flag B");
        chk("R7 both irqs", {14'd0, irq_a_out, irq_b_out}, 16'd0);
        rd(ra(9), 8'h09, "R9 port A");
        rd(rb(9), 8'h7E, "R9 port B");
        chk("R9 both cleared", {14'd0, irq_a_out, irq_b_out}, 16'd3);

        // R10 hardware-owned registers ignore writes
        wr(ra(7), 8'hFF);
        wr(ra(8), 8'h00);
        wr(ra(9), 8'h00);
        rd(ra(7), 8'h00, "R10 flag write ignored");
        rd(ra(8), 8'h09, "R10 capture write ignored");
        rd(ra(9), 8'h09, "R10 port write ignored");

        // R6 level mode with capture-read clearing (R9)
        wr(ra(5), 8'h01);
        wr(ra(4), 8'h10);
        wr(ra(3), 8'h00);
        wr(ra(2), 8'h10);
        pin_in[7:0] = 8'h19;
        idle(3);
        rd(ra(7), 8'h10, "R6 level flag");
        rd(ra(9), 8'h19, "R9 port read sel=1");
        chk("R9 port no clear sel=1", {15'd0, irq_a_out}, 16'd0);
        rd(ra(8), 8'h19, "R9 capture read");
        chk("R6 cleared", {15'd0, irq_a_out}, 16'd1);
        @(negedge clk);
        chk("R6 refire", {15'd0, irq_a_out}, 16'd0);
        pin_in[7:0] = 8'h09;
        idle(3);
        rd(ra(8), 8'h19, "R8 capture on refire");
        idle(2);
        chk("R6 no refire", {15'd0, irq_a_out}, 16'd1);

        // R12 output stage
        wr(ra(5), 8'h02);
        chk("R12 active-high idle", {14'd0, irq_a_out, irq_b_out}, 16'd0);
        pin_in[15:8] = 8'h7F;
        idle(3);
        rd(rb(7), 8'h01, "R7 flag B pin0");
        chk("R12 active-high B", {14'd0, irq_a_out, irq_b_out}, 16'd1);
        wr(ra(5), 8'h42);
        chk("R12 mirror", {15'd0, irq_a_out}, 16'd1);
        wr(ra(5), 8'h46);
        chk("R12 open drain lvl", {14'd0, irq_a_out, irq_b_out}, 16'd0);
        chk("R12 open drain oe", {14'd0, irq_a_oe, irq_b_oe}, 16'd3);
        rd(rb(9), 8'h7F, "R9 port B");
        chk("R12 open drain released", {14'd0, irq_a_oe, irq_b_oe}, 16'd0);

        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule